// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is the address sequencing engine of one DMA channel. It is given a base byte address, a row length, a step within a row, a row count and a step between rows. From these it produces a stream of element addresses, one per handshake with the transfer engine downstream. Both steps are signed element counts. They are scaled to bytes by the element size (1, 2 or 4 bytes), so the step between rows may be smaller than a row's span, or negative. This lets the generator walk interleaved data one channel at a time and de-interleave it. A 1-D transfer is the case where the row count is one.

A pass covers every element of every row. In stop mode the generator halts after one pass and holds done. In autobuffer mode it reloads the base address and both counts at the end of each pass and goes on with no gap. An interrupt pulse marks the end of each pass. When row interrupts are enabled it also marks the end of every row, which gives fractional-buffer interrupts in a circular buffer. The configuration inputs are sampled only when a start is accepted.

The controller has three named states. ST_IDLE follows reset. ST_RUN presents addresses. ST_HALT is the stop-mode end state with done high. It has these transitions:
- GO: from ST_IDLE or ST_HALT to ST_RUN, on start.
- FINISH: from ST_RUN to ST_HALT, when the last element of a pass is accepted in stop mode.
- WRAP: from ST_RUN back to ST_RUN, when the last element is accepted in autobuffer mode.

Top module: `agen2d_core`

## Requirements
- R1: After reset, valid, done and irq are all low.
- R2: A start in ST_IDLE or ST_HALT samples the configuration. From the next cycle valid is high and addr equals the base address.
- R3: Within a row, each accepted handshake (valid and ready both high at a clock edge) moves addr by the inner step times the element size. While ready is low, addr and valid hold.
- R4: An accepted handshake on the last element of a row that is not the last row moves addr by the outer step times the element size. Both steps are signed 16-bit values, so negative steps are allowed.
- R5: A count input of 0 means 65536 elements or rows.
- R6: In stop mode, the cycle after the last element of a pass is accepted, valid is low and done is high. done stays high until the next start.
- R7: In autobuffer mode, the cycle after the last element of a pass is accepted, valid stays high and addr equals the base address again. The counts are reloaded.
- R8: irq is high for exactly the cycle after the handshake that accepts the last element of a pass, in both modes.
- R9: With row interrupts enabled, irq is also high for the cycle after the handshake that accepts the last element of any row. With them disabled, it is low there.
- R10: Element size code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes.
- R11: start is ignored while in ST_RUN. The address sequence in progress continues unchanged, even if the configuration inputs change.
- R12: With a row count of one, the generator performs a linear 1-D pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (ignored while running) |
| base_addr | input | AW (32) | Byte address of the first element |
| row_len | input | CW (16) | Elements per row, 0 means 65536 |
| row_step | input | SW (16) | Signed inner step in elements |
| row_cnt | input | CW (16) | Rows per pass, 0 means 65536 |
| col_step | input | SW (16) | Signed outer step in elements |
| elem_size | input | 2 | Element size code |
| auto_mode | input | 1 | 1 = autobuffer, 0 = stop |
| row_irq_en | input | 1 | Interrupt at the end of every row |
| ready | input | 1 | Downstream accepts the current address |
| addr | output | AW (32) | Current element byte address |
| valid | output | 1 | addr is meaningful (ST_RUN) |
| done | output | 1 | Stop-mode pass complete (ST_HALT) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Errors in the row or pass counters show up as a wrong address at the first row boundary, or as done and irq arriving one element early or late. In either case the first address check after the bad count exposes the error. A wrong stored step or element scale corrupts the address one handshake after the start. A stall that is not honoured changes addr while ready is low, which is visible in the same cycle. A state register that goes wrong is seen within a cycle: valid and done would overlap, or valid would drop in autobuffer mode.

// File: rtl/agen2d_pkg.sv
package agen2d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } agen_state_t;

    // Left shift that turns an element count into bytes
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        logic [1:0] sh;
        unique case (code)
            2'd0:    sh = 2'd0;
            2'd1:    sh = 2'd1;
            default: sh = 2'd2;
        endcase
        return sh;
    endfunction
endpackage

// File: rtl/agen2d_step.sv
module agen2d_step #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic [SW-1:0] stride,
    input  logic [1:0]    esize,
    output logic [AW-1:0] step
);
    import agen2d_pkg::*;

    logic [AW-1:0] ext;

    generate
        if (AW > SW) begin : g_ext
            assign ext = {{(AW-SW){stride[SW-1]}}, stride};
        end else begin : g_trunc
            assign ext = stride[AW-1:0];
        end
    endgenerate

    assign step = ext << size_shift(esize);
endmodule

// File: rtl/agen2d_cnt.sv
module agen2d_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/agen2d_core.sv
module agen2d_core #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] row_len,
    input  logic [SW-1:0] row_step,
    input  logic [CW-1:0] row_cnt,
    input  logic [SW-1:0] col_step,
    input  logic [1:0]    elem_size,
    input  logic          auto_mode,
    input  logic          row_irq_en,
    input  logic          ready,
    output logic [AW-1:0] addr,
    output logic          valid,
    output logic          done,
    output logic          irq
);
    import agen2d_pkg::*;

    agen_state_t state_q, state_d;

    logic [AW-1:0] addr_q, base_q, istep_q, ostep_q;
    logic [AW-1:0] istep_in, ostep_in;
    logic [CW-1:0] len_m1_q, rows_m1_q;
    logic          auto_q, rirq_q, irq_q;
    logic          go, acc, row_end, pass_end, i_last, o_last;

    // Counts are stored minus one; 0 wraps to all ones, i.e. 65536 elements
    localparam logic [CW-1:0] ONE = CW'(1);

    agen2d_step #(.AW(AW), .SW(SW)) u_istep (
        .stride(row_step), .esize(elem_size), .step(istep_in)
    );
    agen2d_step #(.AW(AW), .SW(SW)) u_ostep (
        .stride(col_step), .esize(elem_size), .step(ostep_in)
    );

    assign go       = start && (state_q != ST_RUN);
    assign acc      = (state_q == ST_RUN) && ready;
    assign row_end  = i_last;
    assign pass_end = i_last && o_last;

    agen2d_cnt #(.CW(CW)) u_icnt (
        .clk(clk), .rst_n(rst_n),
        .load(go || (acc && row_end)),
        .load_val(go ? (row_len - ONE) : len_m1_q),
        .dec(acc && !row_end),
        .last(i_last)
    );

    agen2d_cnt #(.CW(CW)) u_ocnt (
        .clk(clk), .rst_n(rst_n),
        .load(go || (acc && pass_end)),
        .load_val(go ? (row_cnt - ONE) : rows_m1_q),
        .dec(acc && row_end && !pass_end),
        .last(o_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (acc && pass_end && !auto_q) state_d = ST_HALT;
            ST_HALT: if (start) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            istep_q   <= '0;
            ostep_q   <= '0;
            len_m1_q  <= '0;
            rows_m1_q <= '0;
            auto_q    <= 1'b0;
            rirq_q    <= 1'b0;
        end else if (go) begin
            base_q    <= base_addr;
            istep_q   <= istep_in;
            ostep_q   <= ostep_in;
            len_m1_q  <= row_len - ONE;
            rows_m1_q <= row_cnt - ONE;
            auto_q    <= auto_mode;
            rirq_q    <= row_irq_en;
        end
    end

    // Address and interrupt datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= acc && (pass_end || (row_end && rirq_q));
            if (go) begin
                addr_q <= base_addr;
            end else if (acc) begin
                if (pass_end) begin
                    if (auto_q) addr_q <= base_q;
                end else if (row_end) begin
                    addr_q <= addr_q + ostep_q;
                end else begin
                    addr_q <= addr_q + istep_q;
                end
            end
        end
    end

    // Output decode
    always_comb begin
        valid = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  valid = 1'b1;
            ST_HALT: done  = 1'b1;
            default: ;
        endcase
    end

    assign addr = addr_q;
    assign irq  = irq_q;
endmodule

// File: rtl/agen2d_chk.sv
module agen2d_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          ready,
    input logic [AW-1:0] addr,
    input logic          valid,
    input logic          done,
    input logic          irq
);
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(addr)); // R3
    AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R6
    AST_IRQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(valid && ready)); // R8
    AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        valid && start && !ready |=> $stable(addr)); // R11
endmodule

bind agen2d_core agen2d_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .addr(addr), .valid(valid), .done(done), .irq(irq)
);

// File: tb/sim_agen2d_core.sv
module sim_agen2d_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] row_len = '0, row_step = '0, row_cnt = '0, col_step = '0;
    logic [1:0]  elem_size = '0;
    logic        auto_mode = 1'b0, row_irq_en = 1'b0, ready = 1'b1;
    logic [31:0] addr;
    logic        valid, done, irq;

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    agen2d_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .row_len(row_len), .row_step(row_step), .row_cnt(row_cnt),
        .col_step(col_step), .elem_size(elem_size), .auto_mode(auto_mode),
        .row_irq_en(row_irq_en), .ready(ready), .addr(addr), .valid(valid),
        .done(done), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One or more passes, checking every address, irq and end state
    task automatic run_pass(input logic [31:0] sa, input logic [15:0] ic, input int is,
                            input logic [15:0] oc, input int os, input logic [1:0] es,
                            input bit am, input bit rie, input int passes,
                            input bit stall, input bit poke, input string tag);
        int ni, no, bytes;
        logic [31:0] a;
        bit lrow, lpass;
        ni = (ic == 0) ? 65536 : int'(ic);
        no = (oc == 0) ? 65536 : int'(oc);
        bytes = (es == 2'd0) ? 1 : (es == 2'd1) ? 2 : 4;   // R10 encoding
        base_addr = sa; row_len = ic; row_step = 16'(is); row_cnt = oc;
        col_step = 16'(os); elem_size = es; auto_mode = am; row_irq_en = rie;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < passes; p++) begin
            a = sa;
            for (int r = 0; r < no; r++) begin
                for (int c = 0; c < ni; c++) begin
                    chk(valid == 1'b1, {tag, "/R2 valid"}, 32'(valid), 32'd1);
                    chk(addr == a, (r == 0 && c == 0) ? {tag, "/R2 addr"} :
                        (c == 0) ? {tag, "/R4 addr"} : {tag, "/R3 addr"}, addr, a);
                    if (stall) begin
                        ready = 1'b0;
                        for (int k = 0; k < 2; k++) begin
                            @(posedge clk); @(negedge clk);
                            chk(valid && addr == a, {tag, "/R3 stall"}, addr, a);
                        end
                        ready = 1'b1;
                    end
                    if (poke && r == 0 && c == 0) begin
                        start = 1'b1; base_addr = sa ^ 32'h00FF_0000; row_len = 16'd9;
                    end
                    @(posedge clk); @(negedge clk);
                    if (poke) begin
                        start = 1'b0; base_addr = sa; row_len = ic;
                    end
                    lrow = (c == ni - 1);
                    lpass = lrow && (r == no - 1);
                    chk(irq == (lpass || (lrow && rie)), lpass ? {tag, "/R8 irq"} : {tag, "/R9 irq"},
                        32'(irq), 32'(lpass || (lrow && rie)));
                    if (lrow) a = a + 32'(os * bytes);
                    else      a = a + 32'(is * bytes);
                end
            end
        end
        if (am) begin
            chk(valid && addr == sa, {tag, "/R7 reload"}, addr, sa);
        end else begin
            chk(!valid && done, {tag, "/R6 done"}, {30'd0, valid, done}, 32'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: quiet after reset
        chk(!valid && !done && !irq, "R1 reset", {29'd0, valid, done, irq}, 32'd0);
        // R12 + R10: 1-D linear pass, 4-byte elements
        run_pass(32'h0000_1000, 16'd5, 1, 16'd1, 1, 2'd2, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R12");
        // R6: done persists with no start
        repeat (3) @(negedge clk);
        chk(done && !valid, "R6 hold", {30'd0, valid, done}, 32'd1);
        // R4/R9: de-interleave 4 byte channels, 3 samples each, row interrupts on
        run_pass(32'h0000_2000, 16'd3, 4, 16'd4, -7, 2'd0, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R4");
        // R10/R3/R11: 2-byte, negative inner step, stalls and ignored start
        run_pass(32'h0000_3000, 16'd3, -2, 16'd2, 10, 2'd1, 1'b0, 1'b0, 1, 1'b1, 1'b1, "R11");
        // R10: code 3 behaves as 4 bytes
        run_pass(32'h0000_4000, 16'd2, 3, 16'd2, -1, 2'd3, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R10");
        // R7/R8: autobuffer, two passes with no row irq
        run_pass(32'h0000_5000, 16'd2, 1, 16'd3, 5, 2'd0, 1'b1, 1'b0, 2, 1'b0, 1'b0, "R7");
        do_reset();
        chk(!valid && !done && !irq, "R1 reset2", {29'd0, valid, done, irq}, 32'd0);
        // R5: row length 0 means 65536
        run_pass(32'h0010_0000, 16'd0, 1, 16'd1, 1, 2'd0, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R5");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule